// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

The block watches a two-wire serial bus (a clock line and a data line) without ever driving it. Both lines pass through a short flop synchronizer. The block then classifies each data-line transition that happens while the clock line is high. It reports start, repeated-start and stop conditions as one-cycle pulses. It also keeps a level busy flag that covers the whole transaction plus a programmable quiet time after the stop.

During a transaction it counts clock rising edges within each byte: eight data bits and one acknowledge slot. It pulses a byte-complete flag on the acknowledge clock and shows the running bit index. A data transition during a clock-high phase deep inside a byte is not a legal start or stop. Such a transition is reported as an abort. After an abort the monitor ignores clock activity until the bus presents a fresh start or stop. A protocol engine or bus arbiter uses these pulses to follow the bus state without decoding any data.

Top module: `twb_cond_mon`

## Requirements
- R1: A falling data line while the clock line is high, outside a transaction, gives one `start_o` pulse. In that cycle `busy_o` is high and `bit_idx_o` is 0.
- R2: The same transition seen inside a transaction (after a start, before a stop) gives `rstart_o` and not `start_o`. `busy_o` stays high and `bit_idx_o` returns to 0.
- R3: A rising data line while the clock line is high gives one `stop_o` pulse and ends the transaction.
- R4: After a stop, `busy_o` stays high for exactly `holdoff_i` system clock cycles, counting the cycle of the `stop_o` pulse. With `holdoff_i` = 0, `busy_o` is already low in the `stop_o` cycle.
- R5: A start that arrives during the post-stop quiet time is reported on `start_o` (not `rstart_o`), and `busy_o` stays high without a gap.
- R6: Inside a transaction, each clock-line rising edge advances `bit_idx_o` by one, from 1 up to 8 on the eighth data bit. A data change made while the clock line is low, or together with its fall, produces no pulse.
- R7: The ninth clock rising edge of a byte (the acknowledge slot) gives one `byte_done_o` pulse, and `bit_idx_o` wraps to 0 in the same cycle.
- R8: A data-line transition during a clock-high phase is a legal start or stop while `bit_idx_o` is 0 or 1. When `bit_idx_o` is 2 to 8, it gives `abort_o` instead, with no start, repeated-start or stop pulse. `bit_idx_o` goes to 0 and `busy_o` stays high.
- R9: After an abort, clock rising edges do not move `bit_idx_o`. The next start is reported on `start_o`, and the next stop on `stop_o` with the normal quiet time.
- R10: Clock-line rising edges outside a transaction leave `bit_idx_o` at 0 and produce no pulse.
- R11: After reset all pulse outputs are low, `bit_idx_o` is 0 and `busy_o` is low; both lines are taken as idle high.
- R12: Each pulse lasts one cycle. At most one of `start_o`, `rstart_o`, `stop_o` and `abort_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| holdoff_i | input | HOLD_W | Post-stop busy time in system clocks |
| start_o | output | 1 | Start condition pulse |
| rstart_o | output | 1 | Repeated start condition pulse |
| stop_o | output | 1 | Stop condition pulse |
| byte_done_o | output | 1 | Acknowledge clock of a byte seen |
| abort_o | output | 1 | Illegal mid-byte data change pulse |
| busy_o | output | 1 | Bus busy level |
| bit_idx_o | output | IDX_W | Clock edges counted in the current byte |

## Verification
The main pattern is a full write-like transaction. It consists of idle clock toggles, a start, a byte with alternating and repeated data values plus an acknowledge, a repeated start, and a stop in the first bit slot. This pattern separates counted from uncounted clock edges, legal from illegal high-phase transitions, and start from repeated start. A second pattern raises the data line at bit two of a byte. It shows that an abort suppresses stop reporting and freezes counting until a new condition. Hold-off runs with a zero and a non-zero delay, and a start inside the quiet time, measure the exact busy duration. They also show that a start in the quiet time is not treated as a repeated start.

// File: rtl/twb_pkg.sv
package twb_pkg;
  // raw line events decoded from the synchronized lines
  typedef struct packed {
    logic fall_hi;   // data fell while clock held high
    logic rise_hi;   // data rose while clock held high
    logic clk_rise;  // clock rising edge
  } twb_line_evt_t;

  // classified condition events
  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
    logic abort;
    logic byte_done;
  } twb_cond_t;
endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
  parameter int NLINE  = 2,
  parameter int NSTAGE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NLINE-1:0] d_i,
  output logic [NLINE-1:0] q_o
);
  for (genvar l = 0; l < NLINE; l++) begin : g_line
    logic [NSTAGE-1:0] stg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '1;  // lines idle high
      else         stg_q <= {stg_q[NSTAGE-2:0], d_i[l]};
    end
    assign q_o[l] = stg_q[NSTAGE-1];
  end
endmodule

// File: rtl/twb_line_dec.sv
module twb_line_dec
  import twb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output twb_line_evt_t evt_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  logic clk_hi;
  assign clk_hi = scl_q & scl_i;

  always_comb begin
    evt_o.fall_hi  = clk_hi & sda_q & ~sda_i;
    evt_o.rise_hi  = clk_hi & ~sda_q & sda_i;
    evt_o.clk_rise = ~scl_q & scl_i;
  end
endmodule

// File: rtl/twb_bit_ctrl.sv
module twb_bit_ctrl
  import twb_pkg::*;
#(
  parameter  int DATA_BITS = 8,
  localparam int IDX_W     = $clog2(DATA_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  twb_line_evt_t    evt_i,
  output twb_cond_t        cond_o,     // combinational, this cycle
  output twb_cond_t        pulse_o,    // registered pulses
  output logic             in_xfer_o,
  output logic             aborted_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DATA_BITS);
  localparam logic [IDX_W-1:0] FIRST_MID = IDX_W'(2);  // from here a high-phase change is illegal

  logic             in_xfer_q, aborted_q;
  logic [IDX_W-1:0] idx_q;
  twb_cond_t        pulse_q;
  logic             hi_chg, mid_byte, count_en;

  always_comb begin
    hi_chg   = evt_i.fall_hi | evt_i.rise_hi;
    mid_byte = in_xfer_q && (idx_q >= FIRST_MID);
    count_en = in_xfer_q && evt_i.clk_rise;

    cond_o.abort     = hi_chg && mid_byte;
    cond_o.start     = evt_i.fall_hi && !mid_byte && !in_xfer_q;
    cond_o.rstart    = evt_i.fall_hi && !mid_byte && in_xfer_q;
    cond_o.stop      = evt_i.rise_hi && !mid_byte;
    cond_o.byte_done = count_en && (idx_q == LAST_IDX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_xfer_q <= 1'b0;
      aborted_q <= 1'b0;
      idx_q     <= '0;
      pulse_q   <= '0;
    end else begin
      pulse_q <= cond_o;
      if (cond_o.start || cond_o.rstart) begin
        in_xfer_q <= 1'b1;
        aborted_q <= 1'b0;
        idx_q     <= '0;
      end else if (cond_o.stop) begin
        in_xfer_q <= 1'b0;
        aborted_q <= 1'b0;
        idx_q     <= '0;
      end else if (cond_o.abort) begin
        in_xfer_q <= 1'b0;
        aborted_q <= 1'b1;
        idx_q     <= '0;
      end else if (count_en) begin
        idx_q <= cond_o.byte_done ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign pulse_o   = pulse_q;
  assign in_xfer_o = in_xfer_q;
  assign aborted_o = aborted_q;
  assign idx_o     = idx_q;
endmodule

// File: rtl/twb_holdoff.sv
module twb_holdoff #(
  parameter int HOLD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clr_i,
  input  logic [HOLD_W-1:0] val_i,
  output logic              active_o
);
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/twb_cond_mon.sv
module twb_cond_mon
  import twb_pkg::*;
#(
  parameter  int HOLD_W      = 16,
  parameter  int SYNC_STAGES = 2,
  parameter  int DATA_BITS   = 8,
  localparam int IDX_W       = $clog2(DATA_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [HOLD_W-1:0] holdoff_i,
  output logic              start_o,
  output logic              rstart_o,
  output logic              stop_o,
  output logic              byte_done_o,
  output logic              abort_o,
  output logic              busy_o,
  output logic [IDX_W-1:0]  bit_idx_o
);
  logic [1:0]    line_s;
  twb_line_evt_t evt;
  twb_cond_t     cond, pulse;
  logic          in_xfer, aborted, hold_act;

  twb_sync #(.NLINE(2), .NSTAGE(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  twb_line_dec u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (line_s[1]),
    .sda_i (line_s[0]),
    .evt_o (evt)
  );

  twb_bit_ctrl #(.DATA_BITS(DATA_BITS)) u_bit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .cond_o   (cond),
    .pulse_o  (pulse),
    .in_xfer_o(in_xfer),
    .aborted_o(aborted),
    .idx_o    (bit_idx_o)
  );

  twb_holdoff #(.HOLD_W(HOLD_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cond.stop),
    .clr_i   (cond.start | cond.rstart),
    .val_i   (holdoff_i),
    .active_o(hold_act)
  );

  assign start_o     = pulse.start;
  assign rstart_o    = pulse.rstart;
  assign stop_o      = pulse.stop;
  assign byte_done_o = pulse.byte_done;
  assign abort_o     = pulse.abort;
  // an aborted bus stays owned until a new condition resolves it
  assign busy_o      = in_xfer | aborted | hold_act;
endmodule

// File: rtl/twb_cond_mon_chk.sv
module twb_cond_mon_chk #(
  parameter int HOLD_W    = 16,
  parameter int DATA_BITS = 8,
  parameter int IDX_W     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [HOLD_W-1:0] holdoff_i,
  input logic              start_o,
  input logic              rstart_o,
  input logic              stop_o,
  input logic              byte_done_o,
  input logic              abort_o,
  input logic              busy_o,
  input logic [IDX_W-1:0]  bit_idx_o
);
  a_r1_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o && bit_idx_o == '0);

  a_r2_rstart_prior_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rstart_o |-> busy_o && $past(busy_o) && bit_idx_o == '0);

  a_r4_stop_holdoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> busy_o == ($past(holdoff_i) != '0));

  a_r6_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_idx_o <= IDX_W'(DATA_BITS));

  a_r7_byte_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> bit_idx_o == '0 && $past(bit_idx_o) == IDX_W'(DATA_BITS));

  a_r8_abort_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> busy_o && bit_idx_o == '0 && $past(bit_idx_o) >= IDX_W'(2));

  a_r12_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, rstart_o, stop_o, abort_o}));

  a_r12_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || rstart_o || stop_o || abort_o || byte_done_o) |=>
      !(start_o || rstart_o || stop_o || abort_o || byte_done_o));
endmodule

bind twb_cond_mon twb_cond_mon_chk #(
  .HOLD_W(HOLD_W), .DATA_BITS(DATA_BITS), .IDX_W(IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .holdoff_i  (holdoff_i),
  .start_o    (start_o),
  .rstart_o   (rstart_o),
  .stop_o     (stop_o),
  .byte_done_o(byte_done_o),
  .abort_o    (abort_o),
  .busy_o     (busy_o),
  .bit_idx_o  (bit_idx_o)
);

// File: tb/twb_cond_mon_tb.sv
module twb_cond_mon_tb;
  localparam int HOLD_W = 16;
  localparam int NV     = 37;
  // vector: {scl, sda, flags{abort,byte,stop,rstart,start}, idx[3:0], busy}
  localparam logic [11:0] VEC [NV] = '{
    {2'b11, 5'h00, 4'd0, 1'b0},  // idle
    {2'b01, 5'h00, 4'd0, 1'b0},  // R10 idle clock low
    {2'b11, 5'h00, 4'd0, 1'b0},  // R10 idle rise not counted
    {2'b10, 5'h01, 4'd0, 1'b1},  // R1 start
    {2'b01, 5'h00, 4'd0, 1'b1},
    {2'b11, 5'h00, 4'd1, 1'b1},  // bit 1 = 1
    {2'b00, 5'h00, 4'd1, 1'b1},
    {2'b10, 5'h00, 4'd2, 1'b1},  // 0
    {2'b01, 5'h00, 4'd2, 1'b1},
    {2'b11, 5'h00, 4'd3, 1'b1},  // 1
    {2'b00, 5'h00, 4'd3, 1'b1},
    {2'b10, 5'h00, 4'd4, 1'b1},  // 0
    {2'b00, 5'h00, 4'd4, 1'b1},
    {2'b10, 5'h00, 4'd5, 1'b1},  // 0 repeated
    {2'b01, 5'h00, 4'd5, 1'b1},
    {2'b11, 5'h00, 4'd6, 1'b1},  // 1
    {2'b00, 5'h00, 4'd6, 1'b1},
    {2'b10, 5'h00, 4'd7, 1'b1},  // 0
    {2'b01, 5'h00, 4'd7, 1'b1},
    {2'b11, 5'h00, 4'd8, 1'b1},  // 1
    {2'b00, 5'h00, 4'd8, 1'b1},  // ack driven low
    {2'b10, 5'h08, 4'd0, 1'b1},  // R7 ack clock
    {2'b01, 5'h00, 4'd0, 1'b1},
    {2'b11, 5'h00, 4'd1, 1'b1},
    {2'b10, 5'h02, 4'd0, 1'b1},  // R2 repeated start at idx 1
    {2'b00, 5'h00, 4'd0, 1'b1},
    {2'b10, 5'h00, 4'd1, 1'b1},
    {2'b11, 5'h04, 4'd0, 1'b0},  // R3 stop, hold-off 0 (R4)
    {2'b10, 5'h01, 4'd0, 1'b1},  // R1 start
    {2'b01, 5'h00, 4'd0, 1'b1},
    {2'b11, 5'h00, 4'd1, 1'b1},
    {2'b00, 5'h00, 4'd1, 1'b1},
    {2'b10, 5'h00, 4'd2, 1'b1},
    {2'b11, 5'h10, 4'd0, 1'b1},  // R8 rise at idx 2 -> abort
    {2'b00, 5'h00, 4'd0, 1'b1},
    {2'b10, 5'h00, 4'd0, 1'b1},  // R9 rise ignored
    {2'b11, 5'h04, 4'd0, 1'b0}   // R9 stop after abort
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              scl_i = 1'b1;
  logic              sda_i = 1'b1;
  logic [HOLD_W-1:0] holdoff_i = '0;
  logic start_o, rstart_o, stop_o, byte_done_o, abort_o, busy_o;
  logic [3:0] bit_idx_o;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic [4:0] acc;

  always #4 clk_i = ~clk_i;  // 125 MHz

  twb_cond_mon #(.HOLD_W(HOLD_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .holdoff_i(holdoff_i), .start_o(start_o), .rstart_o(rstart_o),
    .stop_o(stop_o), .byte_done_o(byte_done_o), .abort_o(abort_o),
    .busy_o(busy_o), .bit_idx_o(bit_idx_o)
  );

  function automatic string req_of(input logic [4:0] f);
    if (f[4]) return "R8";
    if (f[3]) return "R7";
    if (f[2]) return "R3";
    if (f[1]) return "R2";
    if (f[0]) return "R1";
    return "R6";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive lines, then gather pulses over a window longer than the 3-cycle latency
  task automatic step(input logic scl, input logic sda);
    @(negedge clk_i);
    scl_i = scl;
    sda_i = sda;
    acc = '0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      acc |= {abort_o, byte_done_o, stop_o, rstart_o, start_o};
    end
  endtask

  task automatic measure_busy(input logic [HOLD_W-1:0] h, input string req);
    int cnt = 0;
    bit seen = 1'b0;
    holdoff_i = h;
    step(1'b1, 1'b0);            // start
    @(negedge clk_i);
    sda_i = 1'b1;                // stop
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_i);
      if (stop_o) seen = 1'b1;
      if (seen && busy_o) cnt++;
      if (seen && !busy_o) break;
    end
    check(req, cnt, 32'(h));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    // R11 reset state
    check("R11", {start_o, rstart_o, stop_o, byte_done_o, abort_o, busy_o, bit_idx_o},
          '0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11], VEC[i][10]);
      check(req_of(VEC[i][9:5]), acc, VEC[i][9:5]);
      check(req_of(VEC[i][9:5]), bit_idx_o, VEC[i][4:1]);
      check("R4", busy_o, VEC[i][0]);
    end

    // R4 hold-off lengths
    measure_busy(16'd7, "R4");
    measure_busy(16'd0, "R4");
    measure_busy(16'd1, "R4");

    // R5 start inside quiet time
    holdoff_i = 16'd60;
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check("R3", acc, 5'h04);
    check("R4", busy_o, 1'b1);
    step(1'b1, 1'b0);
    check("R5", acc, 5'h01);
    repeat (70) @(negedge clk_i);
    check("R5", busy_o, 1'b1);
    holdoff_i = '0;
    step(1'b1, 1'b1);
    check("R3", busy_o, 1'b0);

    // R9 start after abort is a plain start
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    check("R6", bit_idx_o, 4'd2);
    step(1'b1, 1'b1);
    check("R8", acc, 5'h10);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    check("R9", bit_idx_o, 4'd0);
    check("R9", acc, 5'h00);
    step(1'b1, 1'b0);
    check("R9", acc, 5'h01);
    check("R9", busy_o, 1'b1);
    step(1'b1, 1'b1);
    check("R9", acc, 5'h04);

    // R11 reset mid-transaction
    step(1'b1, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R11", {busy_o, bit_idx_o}, '0);
    sda_i = 1'b1;
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R11", busy_o, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule